// File: doc/BRIEF.md
# Frame-Sync Clock-Rate Detector and Inactivity Powerdown

This block watches a once-per-frame sync input against the bit clock that drives it. Frame sync repeats every 125 µs, and the bit clock runs at one of two rates. The number of clock cycles between two consecutive sync rising edges therefore tells the block which rate it is running at: about 256 cycles at the low rate and about 512 at the high rate. The measurement is taken after reset is released. A period that fits neither window is discarded, and the edge that ended it starts a fresh measurement.

Once the rate is known, the block raises a ready flag and arms an inactivity timer. The timer starts again on every sync rising edge. It runs about 500 µs of clock cycles, which is 1024 cycles at the low rate and 2048 at the high rate. If the timer runs out, the block raises one powerdown request that covers both channels of the surrounding codec. A later sync rising edge removes the request. The detected rate is kept until reset is applied again.

Top module: `fsync_supervisor`

## Requirements
- R1: While reset is high, and at the first clock after it, `rate_hi`, `rate_ready` and `pwr_down` are all 0.
- R2: The period is the number of clock edges from one sampled sync rising edge to the next. A period in 248..264 sets `rate_ready`=1 and `rate_hi`=0 on the clock edge that samples the second rising edge.
- R3: A period in 504..520 sets `rate_ready`=1 and `rate_hi`=1 on the clock edge that samples the second rising edge.
- R4: A period outside both windows leaves `rate_ready` at 0. The rising edge that ended that period starts the next measurement.
- R5: At the low rate, `pwr_down` rises on the 1024th clock edge after the last sync rising edge, provided no rising edge arrives in between. It is still 0 after the 1023rd edge.
- R6: At the high rate, the same timeout is 2048 clock edges.
- R7: Every sync rising edge restarts the timeout. A rising edge that lands exactly on the timeout edge prevents powerdown.
- R8: While `pwr_down` is 1, a sync rising edge clears it on the same clock edge that samples it. `rate_hi` and `rate_ready` stay unchanged.
- R9: Only rising edges count. Sync held high is treated as a single edge, both for measurement and for the timeout, and `pwr_down` stays 1 until a new rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | Frame sync, derived from clk |
| rate_hi | output | 1 | 1 = high clock rate detected, 0 = low rate |
| rate_ready | output | 1 | Rate has been detected and is valid |
| pwr_down | output | 1 | Common powerdown request for both channels |

## Verification
A period counter that is off by one shows up as a wrong `rate_ready` value at the first sync edge of a period near a window boundary, so the checks sit at 247/248, 264/265, 503/504 and 520/521. An idle timer that is off by one, or that ignores restarts, moves the rise of `pwr_down` by a cycle. This shows at the 1023/1024 and 2047/2048 edges, and when a frame of exactly 1024 cycles arrives. Corrupted state in the rate register shows as a change of `rate_hi` when the block wakes from powerdown.

// File: rtl/fsync_sup_pkg.sv
package fsync_sup_pkg;
  typedef enum logic [1:0] {
    DET_WAIT    = 2'd0,
    DET_MEASURE = 2'd1,
    DET_LOCKED  = 2'd2
  } det_state_t;
endpackage

// File: rtl/fsync_rise.sv
// Registers the sync input and flags a rising edge in the cycle it is sampled.
module fsync_rise (
  input  logic clk,
  input  logic rst,
  input  logic fsync_in,
  output logic rise
);
  logic fs_q;

  always_ff @(posedge clk) begin
    if (rst) fs_q <= 1'b0;
    else     fs_q <= fsync_in;
  end

  assign rise = fsync_in & ~fs_q;
endmodule

// File: rtl/rate_detect.sv
// Measures the sync period in clocks and classifies it into one of two rates.
module rate_detect
  import fsync_sup_pkg::*;
#(
  parameter int LO_PERIOD = 256,
  parameter int HI_PERIOD = 512,
  parameter int TOL       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic rate_hi,
  output logic rate_ready
);
  localparam int CNT_W = $clog2(HI_PERIOD + TOL + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LO_MIN  = CNT_W'(LO_PERIOD - TOL);
  localparam logic [CNT_W-1:0] LO_MAX  = CNT_W'(LO_PERIOD + TOL);
  localparam logic [CNT_W-1:0] HI_MIN  = CNT_W'(HI_PERIOD - TOL);
  localparam logic [CNT_W-1:0] HI_MAX  = CNT_W'(HI_PERIOD + TOL);

  det_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             lo_hit, hi_hit;

  assign lo_hit = (cnt >= LO_MIN) && (cnt <= LO_MAX);
  assign hi_hit = (cnt >= HI_MIN) && (cnt <= HI_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= DET_WAIT;
      cnt        <= '0;
      rate_hi    <= 1'b0;
      rate_ready <= 1'b0;
    end else begin
      case (st)
        DET_WAIT: begin
          if (rise) begin
            cnt <= CNT_W'(1);
            st  <= DET_MEASURE;
          end
        end
        DET_MEASURE: begin
          if (rise) begin
            if (lo_hit) begin
              rate_hi    <= 1'b0;
              rate_ready <= 1'b1;
              st         <= DET_LOCKED;
            end else if (hi_hit) begin
              rate_hi    <= 1'b1;
              rate_ready <= 1'b1;
              st         <= DET_LOCKED;
            end else begin
              cnt <= CNT_W'(1);
            end
          end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        DET_LOCKED: st <= DET_LOCKED;
        default:    st <= DET_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/idle_timer.sv
// Counts clocks since the last sync edge; requests powerdown at a rate-scaled limit.
module idle_timer #(
  parameter int LO_TIMEOUT = 1024,
  parameter int HI_TIMEOUT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic rate_hi,
  input  logic rise,
  output logic pwr_down
);
  localparam int MAX_T = (HI_TIMEOUT > LO_TIMEOUT) ? HI_TIMEOUT : LO_TIMEOUT;
  localparam int IDL_W = $clog2(MAX_T + 1);
  localparam logic [IDL_W-1:0] LO_LAST = IDL_W'(LO_TIMEOUT - 1);
  localparam logic [IDL_W-1:0] HI_LAST = IDL_W'(HI_TIMEOUT - 1);

  logic [IDL_W-1:0] idle;
  logic [IDL_W-1:0] last;

  assign last = rate_hi ? HI_LAST : LO_LAST;

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      idle     <= '0;
      pwr_down <= 1'b0;
    end else if (rise) begin
      idle     <= '0;
      pwr_down <= 1'b0;
    end else if (idle == last) begin
      pwr_down <= 1'b1;
    end else begin
      idle <= idle + IDL_W'(1);
    end
  end
endmodule

// File: rtl/fsync_supervisor.sv
// Top: clock-rate detection from the frame period and frame-loss powerdown.
module fsync_supervisor #(
  parameter int LO_PERIOD  = 256,
  parameter int HI_PERIOD  = 512,
  parameter int TOL        = 8,
  parameter int LO_TIMEOUT = 1024,
  parameter int HI_TIMEOUT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic fsync_in,
  output logic rate_hi,
  output logic rate_ready,
  output logic pwr_down
);
  logic rise;

  fsync_rise u_rise (
    .clk      (clk),
    .rst      (rst),
    .fsync_in (fsync_in),
    .rise     (rise)
  );

  rate_detect #(
    .LO_PERIOD (LO_PERIOD),
    .HI_PERIOD (HI_PERIOD),
    .TOL       (TOL)
  ) u_det (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .rate_hi    (rate_hi),
    .rate_ready (rate_ready)
  );

  idle_timer #(
    .LO_TIMEOUT (LO_TIMEOUT),
    .HI_TIMEOUT (HI_TIMEOUT)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .armed    (rate_ready),
    .rate_hi  (rate_hi),
    .rise     (rise),
    .pwr_down (pwr_down)
  );
endmodule

// File: rtl/fsync_supervisor_checker.sv
module fsync_supervisor_checker (
  input logic clk,
  input logic rst,
  input logic fsync_in,
  input logic rate_hi,
  input logic rate_ready,
  input logic pwr_down
);
  // R1: reset clears every output on the following edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!rate_hi && !rate_ready && !pwr_down));

  // R2 / R3: ready only appears on an edge that sampled a sync rising edge
  a_r2_ready_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(rate_ready) |-> ($past(fsync_in) && !$past(fsync_in, 2)));

  // R5: powerdown is only requested once a rate is known
  a_r5_pd_needs_rate: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> rate_ready);

  // R7: powerdown never starts on an edge that sampled a rising edge
  a_r7_no_pd_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> !($past(fsync_in) && !$past(fsync_in, 2)));

  // R8: a rising edge during powerdown wakes the block
  a_r8_wake: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && fsync_in && !$past(fsync_in)) |=> !pwr_down);

  // R8: the detected rate is held while ready
  a_r8_rate_kept: assert property (@(posedge clk) disable iff (rst)
    (rate_ready && $past(rate_ready)) |-> $stable(rate_hi));
endmodule

bind fsync_supervisor fsync_supervisor_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .fsync_in   (fsync_in),
  .rate_hi    (rate_hi),
  .rate_ready (rate_ready),
  .pwr_down   (pwr_down)
);

// File: tb/fsync_supervisor_bench.sv
`timescale 1ns/1ps
module fsync_supervisor_bench;
  localparam int LO_P = 256;
  localparam int HI_P = 512;
  localparam int TOLR = 8;
  localparam int LO_T = 1024;
  localparam int HI_T = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fsync_in = 1'b0;
  logic rate_hi, rate_ready, pwr_down;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsync_supervisor u_fsync_supervisor (
    .clk(clk), .rst(rst), .fsync_in(fsync_in),
    .rate_hi(rate_hi), .rate_ready(rate_ready), .pwr_down(pwr_down)
  );

  // 0 = low rate, 1 = high rate, 2 = no lock
  function automatic int classify(int p);
    if (p >= LO_P - TOLR && p <= LO_P + TOLR) return 0;
    if (p >= HI_P - TOLR && p <= HI_P + TOLR) return 1;
    return 2;
  endfunction

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(logic v);
    fsync_in = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick(1'b0);
    check(rate_ready, 0, "R1 ready in reset");
    check(pwr_down, 0, "R1 pwr_down in reset");
    check(rate_hi, 0, "R1 rate_hi in reset");
    rst = 1'b0;
    tick(1'b0);
    check(rate_ready | pwr_down | rate_hi, 0, "R1 after release");
  endtask

  // one frame starting with its rising edge: w high cycles, p-w low
  task automatic frame(int p, int w);
    for (int i = 0; i < p; i++) tick(i < w);
  endtask

  // remainder of a frame whose rising-edge tick was already issued
  task automatic frame_rest(int p, int w);
    for (int i = 1; i < p; i++) tick(i < w);
  endtask

  task automatic lock_case(int p, int w, string tag);
    int c;
    c = classify(p);
    do_reset();
    frame(p, w);
    tick(1'b1);
    check(rate_ready, (c != 2) ? 1 : 0, tag);
    if (c != 2) check(rate_hi, c, tag);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R2 / R3 / R4 window boundaries
    lock_case(256, 1, "R2 period 256");
    lock_case(248, 2, "R2 period 248");
    lock_case(264, 1, "R2 period 264");
    lock_case(247, 1, "R4 period 247");
    lock_case(265, 1, "R4 period 265");
    lock_case(512, 1, "R3 period 512");
    lock_case(504, 1, "R3 period 504");
    lock_case(520, 3, "R3 period 520");
    lock_case(503, 1, "R4 period 503");
    lock_case(521, 1, "R4 period 521");
    lock_case(300, 1, "R4 period 300");

    // R4: a bad period restarts measurement from its closing edge
    frame_rest(256, 1);
    tick(1'b1);
    check(rate_ready, 1, "R4 relock after bad period");
    check(rate_hi, 0, "R4 relock rate");

    // R9: a wide pulse counts once
    lock_case(256, 40, "R9 wide pulse low rate");

    // random periods and widths
    for (int k = 0; k < 20; k++) begin
      int p, w;
      p = $urandom_range(240, 530);
      w = $urandom_range(1, 4);
      lock_case(p, w, $sformatf("R2/R3/R4 random period %0d", p));
    end

    // R5: low-rate timeout and R8 wake
    lock_case(256, 1, "R2 lock before timeout");
    repeat (LO_T - 1) tick(1'b0);
    check(pwr_down, 0, "R5 edge 1023");
    tick(1'b0);
    check(pwr_down, 1, "R5 edge 1024");
    repeat (300) tick(1'b0);
    check(pwr_down, 1, "R9 stays down without edge");
    tick(1'b1);
    check(pwr_down, 0, "R8 wake");
    check(rate_ready, 1, "R8 ready kept");
    check(rate_hi, 0, "R8 rate kept low");
    repeat (LO_T - 1) tick(1'b0);
    check(pwr_down, 0, "R7 restart after wake 1023");
    tick(1'b0);
    check(pwr_down, 1, "R7 restart after wake 1024");

    // R7: frames keep the block awake, including the exact-limit frame
    tick(1'b1);
    check(pwr_down, 0, "R8 wake again");
    frame_rest(LO_T, 1);
    tick(1'b1);
    check(pwr_down, 0, "R7 frame of 1024 no pd");
    for (int k = 0; k < 8; k++) begin
      int p;
      p = $urandom_range(2, LO_T);
      frame_rest(p, $urandom_range(1, 2));
      check(pwr_down, 0, "R7 before edge");
      tick(1'b1);
      check(pwr_down, 0, "R7 random frame");
    end

    // R6 and R9: high-rate timeout with sync held high
    lock_case(512, 2, "R3 lock before timeout");
    repeat (HI_T - 1) tick(1'b1);
    check(pwr_down, 0, "R6/R9 edge 2047 held high");
    tick(1'b1);
    check(pwr_down, 1, "R6/R9 edge 2048 held high");
    tick(1'b0);
    tick(1'b1);
    check(pwr_down, 0, "R8 wake high rate");
    check(rate_hi, 1, "R8 rate kept high");
    repeat (HI_T - 1) tick(1'b0);
    check(pwr_down, 0, "R6 edge 2047");
    tick(1'b0);
    check(pwr_down, 1, "R6 edge 2048");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule